// File: doc/BRIEF.md
# Endpoint Priming Descriptor Fetch Engine

This block gets USB device endpoints ready before the host asks for them. Software first writes a descriptor pointer into the queue-head slot of an endpoint and direction. It then raises that slot's prime bit. The engine reads a four-word transfer descriptor from system memory at that pointer and keeps a copy in the slot's context storage, so that a later host token can be served without walking a list. For a transmit slot, the engine then fetches the first words of packet data and hands them to the transmit buffer. After the last step, the slot's primed status bit goes high.

A slot index joins the endpoint number and the direction. The engine runs one priming sequence at a time and picks waiting slots by a fixed priority. A flush drops a waiting request, clears the primed state, and aborts a sequence that is in progress. A completion pulse from the transfer logic also clears the primed state. The reset input is expected to be released synchronously to `clk` outside this block.

Top module: `ep_prime_engine`

## Requirements
- R1: After reset, every primed bit is 0, `mem_req_valid` is 0 and `pf_valid` is 0.
- R2: Priming a slot issues four reads at the slot's queue-head pointer plus 0, 4, 8 and 12, in that order. The four returned words go into the slot's context. Word k appears on `ctx_desc[32k+31:32k]` when `ctx_sel` selects the slot.
- R3: Slot index = 2*endpoint + direction, where direction 0 is transmit and 1 is receive. A transmit slot then reads LEAD_WORDS (default 2) words at the address held in descriptor word 2, rising by 4. Each returned word appears on `pf_data` with `pf_valid` high and `pf_ep` equal to the endpoint number.
- R4: A receive slot makes exactly four memory reads and no prefetch writes.
- R5: A slot's primed bit rises only after its whole sequence has completed. At most one primed bit rises in any cycle.
- R6: `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is seen. No new request is raised while a response is still owed.
- R7: When several slots wait at once, the lowest slot index is served first. This means the lowest endpoint first, and transmit before receive.
- R8: A prime request for a slot whose primed bit is set is ignored. No memory read follows, and the context is unchanged.
- R9: A flush clears the slot's primed bit in the next cycle. It also discards a prime request that is still waiting for that slot.
- R10: A flush of the slot being primed aborts the sequence. The primed bit stays 0, the context keeps its previous content, and no further prefetch writes appear. The engine then accepts new work.
- R11: A pulse on `xfer_done` for a slot clears that slot's primed bit and leaves the other slots as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prime_req | input | 2*NUM_EP | Prime request, one bit per slot |
| flush_req | input | 2*NUM_EP | Flush request, one bit per slot |
| xfer_done | input | 2*NUM_EP | Transfer-complete pulse, one bit per slot |
| qh_we | input | 1 | Queue-head pointer write enable |
| qh_wslot | input | SW | Slot written by `qh_wptr` |
| qh_wptr | input | AW | Descriptor pointer value |
| ctx_sel | input | SW | Slot whose stored descriptor is shown |
| ctx_desc | output | DESC_WORDS*DW | Stored descriptor of the selected slot |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | AW | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid, in request order |
| mem_rsp_data | input | DW | Read data |
| pf_valid | output | 1 | Prefetch word write strobe |
| pf_ep | output | EPW | Endpoint channel of the prefetch write |
| pf_data | output | DW | Prefetch word |
| primed | output | 2*NUM_EP | Primed status, one bit per slot |

## Verification
The prime function is tried on transmit and receive slots across several endpoints. It runs once with a memory that is always ready and once with a memory that is ready only every other cycle. This shows whether the read count, the addresses and the prefetch channel follow the direction bit, and whether they hold up when the handshake stalls. Three prime requests in one cycle show the service order. Further patterns show that repeat primes are ignored and that the completion pulse clears only its own slot. A flush is applied at each of three points: on a slot that is already primed, on a slot that is still waiting, and on a slot in the middle of its prefetch. These three cases separate clearing the status bit, dropping the queued request and aborting the sequence that is under way.

// File: rtl/prime_pkg.sv
package prime_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DRSP,
    ST_PREQ,
    ST_PRSP,
    ST_COMMIT
  } fetch_st_e;

endpackage

// File: rtl/prime_arb.sv
module prime_arb #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          gnt_any,
  output logic [N-1:0]  gnt_oh,
  output logic [IW-1:0] gnt_idx
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_chain
      assign seen[gi+1] = seen[gi] | req[gi];
      assign gnt_oh[gi] = req[gi] & ~seen[gi];
    end
  endgenerate

  assign gnt_any = seen[N];

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_oh[i]) gnt_idx = IW'(i);
    end
  end

endmodule

// File: rtl/prime_qh_store.sv
module prime_qh_store #(
  parameter int NSLOT = 8,
  parameter int SW    = 3,
  parameter int AW    = 32,
  parameter int DESCW = 128
) (
  input  logic             clk,
  input  logic             qh_we,
  input  logic [SW-1:0]    qh_wslot,
  input  logic [AW-1:0]    qh_wptr,
  input  logic [SW-1:0]    ptr_sel,
  output logic [AW-1:0]    ptr_out,
  input  logic             commit_we,
  input  logic [SW-1:0]    commit_slot,
  input  logic [DESCW-1:0] commit_desc,
  input  logic [SW-1:0]    ctx_sel,
  output logic [DESCW-1:0] ctx_desc
);

  logic [AW-1:0]    ptr_q [NSLOT];
  logic [DESCW-1:0] ctx_q [NSLOT];

  genvar gs;
  generate
    for (gs = 0; gs < NSLOT; gs++) begin : g_slot
      logic ptr_en;
      logic ctx_en;
      assign ptr_en = qh_we && (qh_wslot == SW'(gs));
      assign ctx_en = commit_we && (commit_slot == SW'(gs));

      always_ff @(posedge clk) begin
        if (ptr_en) ptr_q[gs] <= qh_wptr;
      end

      always_ff @(posedge clk) begin
        if (ctx_en) ctx_q[gs] <= commit_desc;
      end
    end
  endgenerate

  assign ptr_out  = ptr_q[ptr_sel];
  assign ctx_desc = ctx_q[ctx_sel];

endmodule

// File: rtl/prime_fetch.sv
module prime_fetch
  import prime_pkg::*;
#(
  parameter int NSLOT      = 8,
  parameter int SW         = 3,
  parameter int EPW        = 2,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int DESC_WORDS = 4,
  parameter int LEAD_WORDS = 2,
  parameter int BUF_WORD   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [SW-1:0]            start_slot,
  input  logic [AW-1:0]            start_ptr,
  input  logic [NSLOT-1:0]         flush_req,
  output logic                     busy,
  output logic [SW-1:0]            act_slot,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [AW-1:0]            mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [DW-1:0]            mem_rsp_data,
  output logic                     pf_valid,
  output logic [EPW-1:0]           pf_ep,
  output logic [DW-1:0]            pf_data,
  output logic                     commit_we,
  output logic [DESC_WORDS*DW-1:0] commit_desc
);

  localparam int MAXW      = (DESC_WORDS > LEAD_WORDS) ? DESC_WORDS : LEAD_WORDS;
  localparam int CW        = $clog2(MAXW + 1);
  localparam int DIW       = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1;
  localparam int BYTES     = DW / 8;
  localparam int SHIFT     = $clog2(BYTES);
  localparam int DESC_LAST = DESC_WORDS - 1;
  localparam int LEAD_LAST = (LEAD_WORDS > 0) ? LEAD_WORDS - 1 : 0;

  fetch_st_e     st_q, st_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] base_q, base_d;
  logic          abort_q, abort_d;
  logic [DW-1:0] stage_q [DESC_WORDS];

  logic          is_tx;
  logic          abort_now;
  logic          stage_en;
  logic [AW-1:0] buf_ptr;
  logic [AW-1:0] word_off;

  assign busy      = (st_q != ST_IDLE);
  assign act_slot  = slot_q;
  assign is_tx     = ~slot_q[0];
  assign abort_now = busy && (abort_q || flush_req[slot_q]);
  assign stage_en  = (st_q == ST_DRSP) && mem_rsp_valid;
  assign buf_ptr   = AW'(stage_q[BUF_WORD]);
  assign word_off  = AW'(cnt_q) << SHIFT;

  assign mem_req_valid = (st_q == ST_DREQ) || (st_q == ST_PREQ);
  assign mem_req_addr  = ((st_q == ST_PREQ) ? buf_ptr : base_q) + word_off;

  assign pf_valid  = (st_q == ST_PRSP) && mem_rsp_valid && !abort_now;
  assign pf_ep     = slot_q[SW-1:1];
  assign pf_data   = mem_rsp_data;
  assign commit_we = (st_q == ST_COMMIT) && !abort_now;

  genvar gw;
  generate
    for (gw = 0; gw < DESC_WORDS; gw++) begin : g_desc
      assign commit_desc[gw*DW +: DW] = stage_q[gw];
    end
  endgenerate

  always_comb begin
    st_d    = st_q;
    slot_d  = slot_q;
    cnt_d   = cnt_q;
    base_d  = base_q;
    abort_d = abort_now;
    unique case (st_q)
      ST_IDLE: begin
        abort_d = 1'b0;
        if (start) begin
          slot_d = start_slot;
          base_d = start_ptr;
          cnt_d  = '0;
          st_d   = ST_DREQ;
        end
      end
      ST_DREQ: begin
        if (mem_req_ready) st_d = ST_DRSP;
      end
      ST_DRSP: begin
        if (mem_rsp_valid) begin
          if (abort_now) begin
            st_d = ST_IDLE;
          end else if (cnt_q == CW'(DESC_LAST)) begin
            cnt_d = '0;
            st_d  = (is_tx && (LEAD_WORDS > 0)) ? ST_PREQ : ST_COMMIT;
          end else begin
            cnt_d = cnt_q + 1'b1;
            st_d  = ST_DREQ;
          end
        end
      end
      ST_PREQ: begin
        if (mem_req_ready) st_d = ST_PRSP;
      end
      ST_PRSP: begin
        if (mem_rsp_valid) begin
          if (abort_now) begin
            st_d = ST_IDLE;
          end else if (cnt_q == CW'(LEAD_LAST)) begin
            st_d = ST_COMMIT;
          end else begin
            cnt_d = cnt_q + 1'b1;
            st_d  = ST_PREQ;
          end
        end
      end
      ST_COMMIT: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      slot_q  <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      slot_q  <= slot_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      abort_q <= abort_d;
    end
  end

  always_ff @(posedge clk) begin
    if (stage_en) stage_q[cnt_q[DIW-1:0]] <= mem_rsp_data;
  end

endmodule

// File: rtl/ep_prime_engine.sv
module ep_prime_engine #(
  parameter int NUM_EP     = 4,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int DESC_WORDS = 4,
  parameter int LEAD_WORDS = 2,
  parameter int BUF_WORD   = 2,
  localparam int NSLOT     = 2 * NUM_EP,
  localparam int EPW       = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int SW        = EPW + 1,
  localparam int DESCW     = DESC_WORDS * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] prime_req,
  input  logic [NSLOT-1:0] flush_req,
  input  logic [NSLOT-1:0] xfer_done,
  input  logic             qh_we,
  input  logic [SW-1:0]    qh_wslot,
  input  logic [AW-1:0]    qh_wptr,
  input  logic [SW-1:0]    ctx_sel,
  output logic [DESCW-1:0] ctx_desc,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             pf_valid,
  output logic [EPW-1:0]   pf_ep,
  output logic [DW-1:0]    pf_data,
  output logic [NSLOT-1:0] primed
);

  logic [NSLOT-1:0] pend_q, pend_d;
  logic [NSLOT-1:0] primed_q, primed_d;
  logic [NSLOT-1:0] act_hit;
  logic [NSLOT-1:0] accept;
  logic [NSLOT-1:0] arb_req;
  logic [NSLOT-1:0] gnt_oh;
  logic [NSLOT-1:0] set_vec;
  logic [SW-1:0]    gnt_idx;
  logic             gnt_any;
  logic             start;
  logic             busy;
  logic [SW-1:0]    act_slot;
  logic [AW-1:0]    start_ptr;
  logic             commit_we;
  logic [DESCW-1:0] commit_desc;

  assign act_hit = busy ? (NSLOT'(1) << act_slot) : '0;
  assign accept  = prime_req & ~flush_req & ~primed_q & ~act_hit;
  assign arb_req = busy ? '0 : (pend_q & ~flush_req);
  assign start   = gnt_any;
  assign set_vec = commit_we ? (NSLOT'(1) << act_slot) : '0;

  always_comb begin
    pend_d   = (pend_q | accept) & ~flush_req & ~(start ? gnt_oh : '0);
    primed_d = (primed_q & ~flush_req & ~xfer_done) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      primed_q <= '0;
    end else begin
      pend_q   <= pend_d;
      primed_q <= primed_d;
    end
  end

  assign primed = primed_q;

  prime_arb #(.N(NSLOT), .IW(SW)) u_arb (
    .req     (arb_req),
    .gnt_any (gnt_any),
    .gnt_oh  (gnt_oh),
    .gnt_idx (gnt_idx)
  );

  prime_qh_store #(.NSLOT(NSLOT), .SW(SW), .AW(AW), .DESCW(DESCW)) u_store (
    .clk         (clk),
    .qh_we       (qh_we),
    .qh_wslot    (qh_wslot),
    .qh_wptr     (qh_wptr),
    .ptr_sel     (gnt_idx),
    .ptr_out     (start_ptr),
    .commit_we   (commit_we),
    .commit_slot (act_slot),
    .commit_desc (commit_desc),
    .ctx_sel     (ctx_sel),
    .ctx_desc    (ctx_desc)
  );

  prime_fetch #(
    .NSLOT(NSLOT), .SW(SW), .EPW(EPW), .AW(AW), .DW(DW),
    .DESC_WORDS(DESC_WORDS), .LEAD_WORDS(LEAD_WORDS), .BUF_WORD(BUF_WORD)
  ) u_fetch (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_slot    (gnt_idx),
    .start_ptr     (start_ptr),
    .flush_req     (flush_req),
    .busy          (busy),
    .act_slot      (act_slot),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .pf_valid      (pf_valid),
    .pf_ep         (pf_ep),
    .pf_data       (pf_data),
    .commit_we     (commit_we),
    .commit_desc   (commit_desc)
  );

endmodule

// File: rtl/ep_prime_engine_chk.sv
module ep_prime_engine_chk #(
  parameter int NSLOT = 8,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSLOT-1:0] flush_req,
  input logic [NSLOT-1:0] primed,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             pf_valid
);

  logic [1:0] owed_q;
  logic       hs;

  assign hs = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else if (hs && !mem_rsp_valid) owed_q <= owed_q + 1'b1;
    else if (!hs && mem_rsp_valid && owed_q != 0) owed_q <= owed_q - 1'b1;
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R6
  one_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q != 0) |-> !mem_req_valid);

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flush_req) |=> ((primed & $past(flush_req)) == '0));

  // R5
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(primed & ~$past(primed)));

  // R3
  pf_from_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> mem_rsp_valid);

endmodule

bind ep_prime_engine ep_prime_engine_chk #(.NSLOT(NSLOT), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush_req     (flush_req),
  .primed        (primed),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .pf_valid      (pf_valid)
);

// File: tb/ep_prime_engine_test.sv
module ep_prime_engine_test;

  localparam int NUM_EP = 4;
  localparam int NSLOT  = 8;
  localparam int LEAD   = 2;
  localparam int NV     = 6;

  // {stall, slot[2:0], ptr[31:0]}
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 3'd0, 32'h0000_1000},
    {1'b1, 3'd1, 32'h0000_2000},
    {1'b0, 3'd2, 32'h0000_3010},
    {1'b1, 3'd3, 32'h0000_0400},
    {1'b0, 3'd6, 32'h0000_7700},
    {1'b1, 3'd7, 32'h0000_8800}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   prime_req = '0;
  logic [7:0]   flush_req = '0;
  logic [7:0]   xfer_done = '0;
  logic         qh_we = 1'b0;
  logic [2:0]   qh_wslot = '0;
  logic [31:0]  qh_wptr = '0;
  logic [2:0]   ctx_sel = '0;
  logic [127:0] ctx_desc;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [31:0]  mem_rsp_data = '0;
  logic         pf_valid;
  logic [1:0]   pf_ep;
  logic [31:0]  pf_data;
  logic [7:0]   primed;

  int checks = 0;
  int fails  = 0;
  bit stall_mode = 1'b0;
  bit finished = 1'b0;

  int hs_n = 0;
  int pf_n = 0;
  int ord_n = 0;
  logic [31:0] pf_log [256];
  logic [1:0]  pf_ep_log [256];
  int          ord [64];
  logic [7:0]  primed_prev = '0;

  always #5 clk = ~clk;

  ep_prime_engine #(.NUM_EP(NUM_EP)) uut (
    .clk(clk), .rst_n(rst_n), .prime_req(prime_req), .flush_req(flush_req),
    .xfer_done(xfer_done), .qh_we(qh_we), .qh_wslot(qh_wslot), .qh_wptr(qh_wptr),
    .ctx_sel(ctx_sel), .ctx_desc(ctx_desc), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .pf_valid(pf_valid), .pf_ep(pf_ep), .pf_data(pf_data), .primed(primed)
  );

  function automatic logic [31:0] mf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0]};
  endfunction

  function automatic logic [127:0] desc_of(input logic [31:0] p);
    return {mf(p + 32'd12), mf(p + 32'd8), mf(p + 32'd4), mf(p)};
  endfunction

  // memory model: in-order, one cycle after acceptance
  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mf(mem_req_addr);
    if (mem_req_valid && mem_req_ready) hs_n <= hs_n + 1;
    if (pf_valid) begin
      pf_log[pf_n[7:0]]    <= pf_data;
      pf_ep_log[pf_n[7:0]] <= pf_ep;
      pf_n <= pf_n + 1;
    end
    primed_prev <= primed;
    for (int i = 0; i < NSLOT; i++) begin
      if (primed[i] && !primed_prev[i]) begin
        ord[ord_n[5:0]] <= i;
        ord_n <= ord_n + 1;
      end
    end
  end

  always @(negedge clk) begin
    mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_ptr(input logic [2:0] s, input logic [31:0] p);
    @(negedge clk);
    qh_we = 1'b1; qh_wslot = s; qh_wptr = p;
    @(negedge clk);
    qh_we = 1'b0;
  endtask

  task automatic pulse_prime(input logic [7:0] m);
    @(negedge clk);
    prime_req = m;
    @(negedge clk);
    prime_req = '0;
  endtask

  task automatic pulse_flush(input logic [7:0] m);
    @(negedge clk);
    flush_req = m;
    @(negedge clk);
    flush_req = '0;
  endtask

  task automatic wait_primed(input int s, input int maxc);
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (primed[s]) break;
    end
  endtask

  task automatic read_ctx(input logic [2:0] s, output logic [127:0] v);
    ctx_sel = s;
    #1;
    v = ctx_desc;
  endtask

  initial begin
    int h0, p0, o0;
    logic [127:0] v;
    logic [31:0] bufp;

    cyc(3);
    // R1 reset state
    chk(primed == '0, "R1 primed after reset", 128'(primed), 128'h0);
    chk(!mem_req_valid, "R1 no request in reset", 128'(mem_req_valid), 128'h0);
    chk(!pf_valid, "R1 no prefetch in reset", 128'(pf_valid), 128'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(2);
    chk(primed == '0, "R1 primed after release", 128'(primed), 128'h0);

    // table-driven prime pass
    for (int e = 0; e < NV; e++) begin
      logic [2:0]  s;
      logic [31:0] p;
      s = VEC[e][34:32];
      p = VEC[e][31:0];
      stall_mode = VEC[e][35];
      set_ptr(s, p);
      h0 = hs_n; p0 = pf_n;
      pulse_prime(8'(1) << s);
      wait_primed(int'(s), 400);
      chk(primed[s], "R5 primed after sequence", 128'(primed), 128'(8'(1) << s));
      cyc(2);
      read_ctx(s, v);
      chk(v == desc_of(p), "R2 stored descriptor", v, desc_of(p));
      if (s[0] == 1'b0) begin
        chk(hs_n - h0 == 4 + LEAD, "R3 transmit read count", 128'(hs_n - h0), 128'(4 + LEAD));
        bufp = mf(p + 32'd8);
        for (int k = 0; k < LEAD; k++) begin
          chk(pf_log[8'(p0 + k)] == mf(bufp + 32'(4 * k)), "R3 lead data",
              128'(pf_log[8'(p0 + k)]), 128'(mf(bufp + 32'(4 * k))));
          chk(pf_ep_log[8'(p0 + k)] == s[2:1], "R3 lead channel",
              128'(pf_ep_log[8'(p0 + k)]), 128'(s[2:1]));
        end
      end else begin
        chk(hs_n - h0 == 4, "R4 receive read count", 128'(hs_n - h0), 128'h4);
        chk(pf_n == p0, "R4 receive no prefetch", 128'(pf_n - p0), 128'h0);
      end
    end
    stall_mode = 1'b0;

    // R8 re-prime of primed slot 0
    h0 = hs_n;
    set_ptr(3'd0, 32'h0000_9900);
    pulse_prime(8'h01);
    cyc(30);
    chk(hs_n == h0, "R8 no reads on re-prime", 128'(hs_n - h0), 128'h0);
    read_ctx(3'd0, v);
    chk(v == desc_of(32'h0000_1000), "R8 context unchanged", v, desc_of(32'h0000_1000));

    // R11 completion clears only its own slot
    @(negedge clk);
    xfer_done = 8'h01;
    @(negedge clk);
    xfer_done = '0;
    chk(primed == 8'hCE, "R11 done clears slot 0 only", 128'(primed), 128'hCE);

    // R9 flush primed slot 1
    pulse_flush(8'h02);
    chk(primed == 8'hCC, "R9 flush clears slot 1", 128'(primed), 128'hCC);

    // R7 priority among simultaneous requests
    pulse_flush(8'hFF);
    set_ptr(3'd5, 32'h0000_5500);
    o0 = ord_n;
    pulse_prime(8'b0010_1100);
    wait_primed(5, 400);
    cyc(3);
    chk(ord_n - o0 == 3, "R7 three slots primed", 128'(ord_n - o0), 128'h3);
    chk(ord[6'(o0)] == 2 && ord[6'(o0 + 1)] == 3 && ord[6'(o0 + 2)] == 5,
        "R7 service order", {ord[6'(o0)], ord[6'(o0 + 1)], ord[6'(o0 + 2)]},
        {32'd2, 32'd3, 32'd5});

    // R10 abort during prefetch
    set_ptr(3'd4, 32'h0000_5000);
    pulse_prime(8'h10);
    wait_primed(4, 400);
    pulse_flush(8'h10);
    set_ptr(3'd4, 32'h0000_6000);
    h0 = hs_n;
    pulse_prime(8'h10);
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (hs_n >= h0 + 5) break;
    end
    p0 = pf_n;
    flush_req = 8'h10;
    @(negedge clk);
    flush_req = '0;
    cyc(30);
    chk(!primed[4], "R10 aborted slot not primed", 128'(primed), 128'h0);
    chk(pf_n == p0, "R10 no prefetch after abort", 128'(pf_n - p0), 128'h0);
    read_ctx(3'd4, v);
    chk(v == desc_of(32'h0000_5000), "R10 context kept", v, desc_of(32'h0000_5000));
    set_ptr(3'd0, 32'h0000_1000);
    pulse_prime(8'h01);
    wait_primed(0, 400);
    chk(primed[0], "R10 engine free after abort", 128'(primed), 128'h1);

    // R9 flush of a waiting request
    pulse_flush(8'hC0);
    h0 = hs_n;
    @(negedge clk);
    prime_req = 8'hC0;
    @(negedge clk);
    prime_req = '0;
    flush_req = 8'h80;
    @(negedge clk);
    flush_req = '0;
    wait_primed(6, 400);
    cyc(40);
    chk(primed[7:6] == 2'b01, "R9 waiting request dropped", 128'(primed[7:6]), 128'h1);
    chk(hs_n - h0 == 4 + LEAD, "R9 only slot 6 fetched", 128'(hs_n - h0), 128'(4 + LEAD));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-all actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule